// File: doc/BRIEF.md
# Grouped Interrupt Trigger Aggregator

This block collects up to 128 interrupt trigger lines, arranged as four groups of 32, and turns them into per-trigger pending state. Trigger `t` sits at group `t / 32`, bit `t % 32`. Each line is set up through a small register port as either edge-sensitive or level-sensitive. An edge-sensitive line records a single event. A level-sensitive line follows a sticky fault condition and sets its pending bit again for as long as the source holds it. Each trigger also has a mask bit and a two-bit severity class.

From the unmasked pending bits the block produces:
- a summary bit per group;
- four severity OR outputs (error, abort, fatal, log);
- a summary of pending bits that are held back by their mask;
- a 32-bit roll-up of one chosen group with its bit order reversed, for a parent that counts queue numbers downward.

A message-request strobe with a vector index asks for one vector per pending, unmasked trigger, lowest index first, and waits for a handshake each time. Message formatting is left to the consumer. Two instances can be paired to cover 256 sources through the `INST_IDX` parameter. The first instance owns vectors 0 to 127 and the second owns 128 to 255.

Each input passes through a two-flop synchronizer, an edge detector and a toggle-to-pulse stage. A per-group bypass bit removes the synchronizer from the path. The edge detector and pulse stage stay in the path when the bypass is set.

Top module: `grp_intc_agg`

## Requirements
- R1: After reset, every pending bit is 0 and every mask bit is 1 (masked). The group summaries, severity outputs, mask summary, roll-up and `msg_req` are all 0.
- R2: Register map, word addressed. Group g occupies offsets g*8+0 to g*8+4:
  - +0: pending (read; write 1 to clear);
  - +1: mask (1 = masked);
  - +2: level select (1 = level, 0 = edge);
  - +3: severity word for bits 0..15, bits [2b+1:2b];
  - +4: severity word for bits 16..31.

  Offset 32 holds the per-group bypass bits, with bit g for group g.
- R3: An edge-type trigger sets its pending bit once for each rising edge, and the bit stays set after the input falls. With the synchronizer in the path, the bit reads 1 four clock edges after the input rises and still reads 0 after three.
- R4: A level-type trigger sets its pending bit while the input is high. If the bit is cleared while the source still holds the input high, it reads 0 right after the clearing write and 1 one clock later.
- R5: Writing 1 to a pending bit clears it. Writing 0 leaves the bit as it was.
- R6: A masked trigger still latches its pending bit but drives no summary, severity output or message. `mask_sum` is 1 while any masked trigger is pending. Unmasking an already-pending trigger makes it contribute from the cycle after the write.
- R7: `grp_sum[g]` is 1 exactly when some unmasked trigger in group g is pending.
- R8: Severity code 0 feeds `sev_or[0]` (error), code 1 feeds `sev_or[1]` (abort), code 2 feeds `sev_or[2]` (fatal), and code 3 feeds `sev_or[3]` (log).
- R9: Vector selection and handshake:
  - `msg_req` is 1 while some unmasked pending trigger has not yet been delivered.
  - `msg_vec` is `INST_IDX*128` plus the lowest such trigger index.
  - A cycle with both `msg_req` and `msg_ack` high delivers that vector.
  - A delivered trigger is requested again only after its pending bit has been cleared and then set again.
- R10: Triggers marked as tied to zero never set a pending bit, whatever their input does. By default these are triggers 124 to 127.
- R11: `q_roll[i]` is the unmasked pending state of trigger `ROLL_GRP*32 + 31 - i`. The default `ROLL_GRP` is 1.
- R12: With the bypass bit set for its group, an edge-type trigger's pending bit reads 1 two clock edges after the input rises. A level-type trigger's bit reads 1 after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 128 | Trigger input bus, bit t = group t/32 bit t%32 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| grp_sum | output | 4 | Per-group unmasked pending summary |
| sev_or | output | 4 | Severity OR outputs: error, abort, fatal, log |
| mask_sum | output | 1 | Some masked trigger is pending |
| q_roll | output | 32 | Bit-reversed roll-up of group `ROLL_GRP` |
| msg_req | output | 1 | Message request strobe |
| msg_ack | input | 1 | Message request accepted |
| msg_vec | output | 8 | Vector index of the requested message |

## Verification
Every pending, mask, level-select and severity bit can be read back through the register port. A wrong bit therefore shows up at `reg_rdata` on the next read of that word. It also shows up the same cycle on the group summary, the severity outputs and the roll-up once the trigger is unmasked. A wrong count in the front-end pipeline shows as a pending bit that arrives one edge early or late. A stuck delivered flag shows as a vector that is either never requested or requested again after its handshake. A reversed or shifted priority shows as the wrong `msg_vec` on the first request.

// File: rtl/gia_pkg.sv
package gia_pkg;
   localparam int REG_W   = 32;
   localparam int NUM_SEV = 4;
   localparam int GRP_SPAN = 8;

   typedef enum logic [1:0] {
      SEV_ERROR = 2'd0,
      SEV_ABORT = 2'd1,
      SEV_FATAL = 2'd2,
      SEV_LOG   = 2'd3
   } sev_e;

   localparam logic [2:0] OFS_PEND  = 3'd0;
   localparam logic [2:0] OFS_MASK  = 3'd1;
   localparam logic [2:0] OFS_LEVEL = 3'd2;
   localparam logic [2:0] OFS_SEVLO = 3'd3;
   localparam logic [2:0] OFS_SEVHI = 3'd4;
endpackage

// File: rtl/gia_front.sv
module gia_front #(
   parameter int NUM_GRP = 4,
   parameter int GRP_W   = 32,
   parameter int SYNC_N  = 2,
   parameter int NT      = NUM_GRP * GRP_W,
   parameter logic [NT-1:0] TIED = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NT-1:0]      trig_in,
   input  logic [NUM_GRP-1:0] byp,
   input  logic [NT-1:0]      level_cfg,
   output logic [NT-1:0]      set_vec
);
   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      for (genvar b = 0; b < GRP_W; b++) begin : g_bit
         localparam int T = g * GRP_W + b;
         if (TIED[T]) begin : g_tied
            assign set_vec[T] = 1'b0 & trig_in[T] & level_cfg[T];
         end else begin : g_live
            logic [SYNC_N-1:0] sync_q;
            logic sel, prev_q, tog_q, tog_d, pulse;

            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  sync_q <= '0;
                  prev_q <= 1'b0;
                  tog_q  <= 1'b0;
                  tog_d  <= 1'b0;
               end else begin
                  sync_q <= {sync_q[SYNC_N-2:0], trig_in[T]};
                  prev_q <= sel;
                  if (sel && !prev_q) tog_q <= ~tog_q;
                  tog_d  <= tog_q;
               end
            end

            assign sel        = byp[g] ? trig_in[T] : sync_q[SYNC_N-1];
            assign pulse      = tog_q ^ tog_d;
            assign set_vec[T] = level_cfg[T] ? sel : pulse;

            // R3: each detected edge yields exactly one single-cycle pulse
            p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
               pulse |=> !pulse);
         end
      end
   end
endmodule

// File: rtl/gia_pend_bank.sv
module gia_pend_bank
   import gia_pkg::*;
#(
   parameter int NUM_GRP = 4,
   parameter int GRP_W   = 32,
   parameter int ADDR_W  = 6,
   parameter int NT      = NUM_GRP * GRP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NT-1:0]      set_vec,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   output logic [NT-1:0]      pend_q,
   output logic [NT-1:0]      mask_q,
   output logic [NT-1:0]      level_q,
   output logic [2*NT-1:0]    sev_q,
   output logic [NUM_GRP-1:0] byp_q
);
   localparam int BYP_ADDR = NUM_GRP * GRP_SPAN;
   localparam int GSEL_W   = ADDR_W - 3;

   logic [REG_W-1:0] rd_grp [NUM_GRP];
   logic             byp_wr;

   assign byp_wr = reg_we && (reg_addr == ADDR_W'(BYP_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      byp_q <= '0;
      else if (byp_wr) byp_q <= reg_wdata[NUM_GRP-1:0];
   end

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam int LO = g * GRP_W;
      logic [GRP_W-1:0]   pend_r, mask_r, lvl_r, clr;
      logic [2*GRP_W-1:0] sev_r;
      logic w_pend, w_mask, w_lvl, w_slo, w_shi;

      assign w_pend = reg_we && (reg_addr == ADDR_W'(g * GRP_SPAN + int'(OFS_PEND)));
      assign w_mask = reg_we && (reg_addr == ADDR_W'(g * GRP_SPAN + int'(OFS_MASK)));
      assign w_lvl  = reg_we && (reg_addr == ADDR_W'(g * GRP_SPAN + int'(OFS_LEVEL)));
      assign w_slo  = reg_we && (reg_addr == ADDR_W'(g * GRP_SPAN + int'(OFS_SEVLO)));
      assign w_shi  = reg_we && (reg_addr == ADDR_W'(g * GRP_SPAN + int'(OFS_SEVHI)));
      assign clr    = w_pend ? reg_wdata[GRP_W-1:0] : '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_r <= '0;
            mask_r <= '1;
            lvl_r  <= '0;
            sev_r  <= '0;
         end else begin
            pend_r <= (pend_r | set_vec[LO +: GRP_W]) & ~clr;
            if (w_mask) mask_r <= reg_wdata[GRP_W-1:0];
            if (w_lvl)  lvl_r  <= reg_wdata[GRP_W-1:0];
            for (int b = 0; b < GRP_W; b++) begin
               if ((b < 16) ? w_slo : w_shi)
                  sev_r[2*b +: 2] <= reg_wdata[2*(b%16) +: 2];
            end
         end
      end

      always_comb begin
         rd_grp[g] = '0;
         case (reg_addr[2:0])
            OFS_PEND:  rd_grp[g] = REG_W'(pend_r);
            OFS_MASK:  rd_grp[g] = REG_W'(mask_r);
            OFS_LEVEL: rd_grp[g] = REG_W'(lvl_r);
            OFS_SEVLO: for (int b = 0; b < GRP_W && b < 16; b++)
                          rd_grp[g][2*b +: 2] = sev_r[2*b +: 2];
            OFS_SEVHI: for (int b = 16; b < GRP_W; b++)
                          rd_grp[g][2*(b-16) +: 2] = sev_r[2*b +: 2];
            default:   rd_grp[g] = '0;
         endcase
      end

      assign pend_q[LO +: GRP_W]      = pend_r;
      assign mask_q[LO +: GRP_W]      = mask_r;
      assign level_q[LO +: GRP_W]     = lvl_r;
      assign sev_q[2*LO +: 2*GRP_W]   = sev_r;

      // R5: a written 1 leaves that pending bit clear after the write edge
      p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
         w_pend |=> ((pend_r & $past(reg_wdata[GRP_W-1:0])) == '0));
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(BYP_ADDR))
         reg_rdata = REG_W'(byp_q);
      else if (int'(reg_addr[ADDR_W-1:3]) < NUM_GRP)
         reg_rdata = rd_grp[reg_addr[ADDR_W-1:3]];
   end

   // R3: a pending bit only rises when the front end asked for it
   p_rise_needs_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & ~$past(pend_q) & ~$past(set_vec)) == '0));

   logic [GSEL_W-1:0] unused_gsel;
   assign unused_gsel = reg_addr[ADDR_W-1:3];
endmodule

// File: rtl/gia_rollup.sv
module gia_rollup
   import gia_pkg::*;
#(
   parameter int NUM_GRP  = 4,
   parameter int GRP_W    = 32,
   parameter int ROLL_GRP = 1,
   parameter int NT       = NUM_GRP * GRP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NT-1:0]      pend_q,
   input  logic [NT-1:0]      mask_q,
   input  logic [2*NT-1:0]    sev_q,
   output logic [NUM_GRP-1:0] grp_sum,
   output logic [NUM_SEV-1:0] sev_or,
   output logic               mask_sum,
   output logic [GRP_W-1:0]   q_roll
);
   logic [NT-1:0] act;
   assign act      = pend_q & ~mask_q;
   assign mask_sum = |(pend_q & mask_q);

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_sum
      assign grp_sum[g] = |act[g*GRP_W +: GRP_W];
   end

   for (genvar i = 0; i < GRP_W; i++) begin : g_roll
      assign q_roll[i] = act[ROLL_GRP*GRP_W + GRP_W - 1 - i];
   end

   always_comb begin
      sev_or = '0;
      for (int t = 0; t < NT; t++) begin
         for (int k = 0; k < NUM_SEV; k++) begin
            if (act[t] && (sev_q[2*t +: 2] == 2'(k))) sev_or[k] = 1'b1;
         end
      end
   end

   // R8: a severity output can only fire when some group reports activity
   p_sev_needs_grp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_sum == '0) |-> (sev_or == '0));
endmodule

// File: rtl/gia_msg_arb.sv
module gia_msg_arb #(
   parameter int NT       = 128,
   parameter int MSG_EN   = 1,
   parameter int INST_IDX = 0,
   parameter int VEC_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NT-1:0]    pend_q,
   input  logic [NT-1:0]    mask_q,
   input  logic             msg_ack,
   output logic             msg_req,
   output logic [VEC_W-1:0] msg_vec
);
   localparam int IDX_W = $clog2(NT);

   if (MSG_EN != 0) begin : g_msg
      logic [NT-1:0]    dlv_q, cand, acc_oh;
      logic [IDX_W-1:0] idx;
      logic             found;

      assign cand = pend_q & ~mask_q & ~dlv_q;

      always_comb begin
         idx   = '0;
         found = 1'b0;
         for (int i = 0; i < NT; i++) begin
            if (cand[i] && !found) begin
               idx   = IDX_W'(i);
               found = 1'b1;
            end
         end
      end

      assign msg_req = found;
      assign msg_vec = VEC_W'(INST_IDX * NT) + VEC_W'(idx);
      assign acc_oh  = (msg_req && msg_ack) ? (NT'(1) << idx) : '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dlv_q <= '0;
         else        dlv_q <= (dlv_q | acc_oh) & pend_q;
      end

      // R9: a request always names an unmasked pending trigger
      p_req_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
         msg_req |-> (pend_q[idx] && !mask_q[idx]));
      // R9: an accepted vector is not offered again on the next cycle
      p_ack_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (msg_req && msg_ack) |=> !(msg_req && (msg_vec == $past(msg_vec))));
   end else begin : g_nomsg
      logic unused_msg;
      assign unused_msg = ^{pend_q, mask_q, msg_ack, clk, rst_n};
      assign msg_req    = 1'b0;
      assign msg_vec    = '0;
   end
endmodule

// File: rtl/grp_intc_agg.sv
module grp_intc_agg
   import gia_pkg::*;
#(
   parameter int NUM_GRP  = 4,
   parameter int GRP_W    = 32,
   parameter int SYNC_N   = 2,
   parameter int ROLL_GRP = 1,
   parameter int MSG_EN   = 1,
   parameter int INST_IDX = 0,
   parameter logic [NUM_GRP*GRP_W-1:0] TIED = {4'hF, {(NUM_GRP*GRP_W-4){1'b0}}},
   localparam int NT     = NUM_GRP * GRP_W,
   localparam int ADDR_W = $clog2(NUM_GRP * GRP_SPAN + 1),
   localparam int VEC_W  = $clog2(2 * NT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NT-1:0]      trig_in,
   input  logic               reg_we,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   output logic [NUM_GRP-1:0] grp_sum,
   output logic [NUM_SEV-1:0] sev_or,
   output logic               mask_sum,
   output logic [GRP_W-1:0]   q_roll,
   output logic               msg_req,
   input  logic               msg_ack,
   output logic [VEC_W-1:0]   msg_vec
);
   if (GRP_W < 1 || GRP_W > REG_W) begin : g_chk_w
      $error("GRP_W must lie in 1..32");
   end
   if (NUM_GRP < 1 || NUM_GRP > 4) begin : g_chk_g
      $error("NUM_GRP must lie in 1..4");
   end
   if (SYNC_N < 2) begin : g_chk_s
      $error("SYNC_N must be at least 2");
   end
   if (ROLL_GRP < 0 || ROLL_GRP >= NUM_GRP) begin : g_chk_r
      $error("ROLL_GRP out of range");
   end
   if (INST_IDX < 0 || INST_IDX > 1) begin : g_chk_i
      $error("INST_IDX must be 0 or 1");
   end

   logic [NT-1:0]      set_vec, pend_q, mask_q, level_q;
   logic [2*NT-1:0]    sev_q;
   logic [NUM_GRP-1:0] byp_q;

   gia_front #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .SYNC_N(SYNC_N), .NT(NT), .TIED(TIED)) u_front (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .byp(byp_q),
      .level_cfg(level_q), .set_vec(set_vec));

   gia_pend_bank #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .ADDR_W(ADDR_W), .NT(NT)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pend_q(pend_q), .mask_q(mask_q), .level_q(level_q), .sev_q(sev_q),
      .byp_q(byp_q));

   gia_rollup #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W), .ROLL_GRP(ROLL_GRP), .NT(NT)) u_roll (
      .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .mask_q(mask_q), .sev_q(sev_q),
      .grp_sum(grp_sum), .sev_or(sev_or), .mask_sum(mask_sum), .q_roll(q_roll));

   gia_msg_arb #(.NT(NT), .MSG_EN(MSG_EN), .INST_IDX(INST_IDX), .VEC_W(VEC_W)) u_msg (
      .clk(clk), .rst_n(rst_n), .pend_q(pend_q), .mask_q(mask_q),
      .msg_ack(msg_ack), .msg_req(msg_req), .msg_vec(msg_vec));
endmodule

// File: tb/grp_intc_agg_bench.sv
module grp_intc_agg_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [127:0] trig_in = '0;
   logic         reg_we = 1'b0;
   logic [5:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic [3:0]   grp_sum, sev_or;
   logic         mask_sum, msg_req;
   logic         msg_ack = 1'b0;
   logic [31:0]  q_roll;
   logic [7:0]   msg_vec;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   grp_intc_agg u_grp_intc_agg (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .grp_sum(grp_sum), .sev_or(sev_or), .mask_sum(mask_sum), .q_roll(q_roll),
      .msg_req(msg_req), .msg_ack(msg_ack), .msg_vec(msg_vec));

   typedef struct packed {
      logic [6:0] idx;
      logic       lvl;
      logic [1:0] sev;
   } vec_t;

   localparam vec_t VT [6] = '{
      '{idx: 7'd0,   lvl: 1'b0, sev: 2'd0},
      '{idx: 7'd31,  lvl: 1'b1, sev: 2'd1},
      '{idx: 7'd32,  lvl: 1'b0, sev: 2'd2},
      '{idx: 7'd63,  lvl: 1'b1, sev: 2'd3},
      '{idx: 7'd64,  lvl: 1'b0, sev: 2'd1},
      '{idx: 7'd100, lvl: 1'b1, sev: 2'd2}
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(logic [5:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         failures++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      rd(6'd0, d);  check("R1 pending g0", d, 32'h0);
      rd(6'd1, d);  check("R1 mask g0", d, 32'hFFFF_FFFF);
      rd(6'd25, d); check("R1 mask g3", d, 32'hFFFF_FFFF);
      rd(6'd32, d); check("R1 bypass", d, 32'h0);
      check("R1 outputs", {grp_sum, sev_or, 23'd0, mask_sum}, 32'h0);
      check("R1 msg_req", {31'd0, msg_req}, 32'h0);
      check("R1 q_roll", q_roll, 32'h0);

      // R3 / R12: synchronized edge latency on group 0
      wr(6'd32, 32'hE);
      trig_in[5] = 1'b1;
      tick(3); rd(6'd0, d); check("R3 synced edge not yet", d, 32'h0);
      tick(1); rd(6'd0, d); check("R3 synced edge at 4", d, 32'h20);
      // R6 masked pending
      check("R6 mask_sum", {31'd0, mask_sum}, 32'h1);
      check("R6 masked grp_sum", {28'd0, grp_sum}, 32'h0);
      wr(6'd1, ~32'h20);
      check("R6 unmask contributes", {28'd0, grp_sum}, 32'h1);
      check("R6 mask_sum drops", {31'd0, mask_sum}, 32'h0);
      wr(6'd0, 32'h20);
      tick(4); rd(6'd0, d); check("R3 edge one-shot while held", d, 32'h0);
      trig_in[5] = 1'b0;
      wr(6'd1, 32'hFFFF_FFFF);
      wr(6'd32, 32'hF);
      // R12 bypass edge latency
      trig_in[6] = 1'b1;
      tick(1); rd(6'd0, d); check("R12 bypass edge not yet", d, 32'h0);
      tick(1); rd(6'd0, d); check("R12 bypass edge at 2", d, 32'h40);
      trig_in[6] = 1'b0;
      wr(6'd0, 32'h40);
      rd(6'd0, d); check("R5 cleared", d, 32'h0);

      // R2 R7 R8 R11 R9 table walk (bypass on)
      for (int i = 0; i < 6; i++) begin
         int g, b;
         logic [31:0] bit_b, exp_roll;
         g = int'(VT[i].idx) / 32;
         b = int'(VT[i].idx) % 32;
         bit_b = 32'h1 << b;
         exp_roll = (g == 1) ? (32'h1 << (31 - b)) : 32'h0;
         wr(6'(g*8+2), VT[i].lvl ? bit_b : 32'h0);
         wr(6'(g*8 + ((b < 16) ? 3 : 4)), 32'(VT[i].sev) << (2*(b%16)));
         wr(6'(g*8+1), ~bit_b);
         trig_in[VT[i].idx] = 1'b1;
         tick(2);
         trig_in[VT[i].idx] = 1'b0;
         tick(2);
         rd(6'(g*8), d);  check("R2 pending word/bit", d, bit_b);
         check("R7 grp_sum", {28'd0, grp_sum}, 32'h1 << g);
         check("R8 sev_or", {28'd0, sev_or}, 32'h1 << VT[i].sev);
         check("R11 q_roll", q_roll, exp_roll);
         check("R9 msg_vec", {23'd0, msg_req, msg_vec}, {23'd0, 1'b1, 1'b0, VT[i].idx});
         wr(6'(g*8), bit_b);
         rd(6'(g*8), d);  check("R5 clear", d, 32'h0);
         wr(6'(g*8+1), 32'hFFFF_FFFF);
         wr(6'(g*8+2), 32'h0);
         wr(6'(g*8 + ((b < 16) ? 3 : 4)), 32'h0);
      end

      // R4 level clear while source held (trigger 71 = group 2 bit 7)
      wr(6'd18, 32'h80);
      trig_in[71] = 1'b1;
      tick(1); rd(6'd16, d); check("R4 level set after 1", d, 32'h80);
      wr(6'd16, 32'h80);
      rd(6'd16, d); check("R4 cleared after write", d, 32'h0);
      tick(1); rd(6'd16, d); check("R4 re-set next cycle", d, 32'h80);
      trig_in[71] = 1'b0;
      wr(6'd16, 32'h80);
      wr(6'd18, 32'h0);
      rd(6'd16, d); check("R5 write zero keeps", d, 32'h0);

      // R10 tied triggers 124..127
      wr(6'd26, 32'h8000_0000);
      wr(6'd25, 32'h0);
      trig_in[127:124] = 4'hF;
      tick(4);
      rd(6'd24, d); check("R10 tied never pending", d, 32'h0);
      check("R10 tied no summary", {28'd0, grp_sum}, 32'h0);
      trig_in[127:124] = 4'h0;
      wr(6'd25, 32'hFFFF_FFFF);
      wr(6'd26, 32'h0);

      // R9 ordering and handshake: triggers 2, 5, 40
      wr(6'd1, ~32'h24);
      wr(6'd9, ~32'h100);
      trig_in[2] = 1'b1; trig_in[5] = 1'b1; trig_in[40] = 1'b1;
      tick(2);
      check("R9 first lowest", {23'd0, msg_req, msg_vec}, {23'd0, 1'b1, 8'd2});
      msg_ack = 1'b1; tick(1); msg_ack = 1'b0;
      check("R9 second", {23'd0, msg_req, msg_vec}, {23'd0, 1'b1, 8'd5});
      msg_ack = 1'b1; tick(1); msg_ack = 1'b0;
      check("R9 third", {23'd0, msg_req, msg_vec}, {23'd0, 1'b1, 8'd40});
      msg_ack = 1'b1; tick(1); msg_ack = 1'b0;
      check("R9 all delivered", {31'd0, msg_req}, 32'h0);
      rd(6'd0, d); check("R9 pending kept", d, 32'h24);
      trig_in[2] = 1'b0; trig_in[5] = 1'b0; trig_in[40] = 1'b0;
      wr(6'd0, 32'h4);
      tick(1);
      trig_in[2] = 1'b1;
      tick(2);
      check("R9 re-request after clear", {23'd0, msg_req, msg_vec}, {23'd0, 1'b1, 8'd2});
      trig_in[2] = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule